// File: doc/BRIEF.md
# Pulse-Width Validated Timestamp Channel

One channel of a coarse-fine time-to-digital converter. Every clock cycle the channel gets a vector of fine phase samples of an asynchronous pulse, already sampled by a delay line, together with a coarse count that is shared among channels. The channel takes the pulse level from the latest phase sample. A 0-to-1 change of that level marks a rising edge, and a 1-to-0 change marks a falling edge.

On each accepted rising edge the channel stores a rise word: the coarse count with the thermometer-encoded fine position below it. A width counter then measures how long the pulse stays high. A pulse narrower than the programmable minimum width counts as noise, and the next rising edge simply overwrites its rise word. A pulse that reaches the minimum width sets the valid flag. The valid flag freezes the rise word and arms a fall capture, which records the coarse count of the falling edge.

A readout agent shifts the two captured words out one bit at a time. It then frees the channel with two separate release commands: one for the rise register and one for the width counter. A phase sample that is not a thermometer code is reported as a sampling error.

Top module: `pulse_stamp_channel`

## Requirements
- R1: While reset is asserted and right after it, `evt_valid`, `phase_err` and `ser_out` are 0.
- R2: The pulse level is `phase_smp[PHASES-1]`. On an accepted rising edge the rise word becomes {`coarse_cnt`, fine}, where fine = (number of ones in `phase_smp`) − 1, taken in that same cycle and held in FINE_W = log2(PHASES) bits.
- R3: Count the cycles in which the level is high, with the rising cycle as cycle 1. `evt_valid` rises at the clock edge that ends cycle N exactly when N reaches `min_width`. A `min_width` of 0 acts as 1.
- R4: A pulse that falls before reaching `min_width` leaves `evt_valid` at 0, and the next accepted rising edge overwrites its rise word.
- R5: After validation, the first falling edge stores `coarse_cnt` from its own cycle into the fall word. The fine bits are not stored for the fall.
- R6: `evt_valid` stays 1 until a rising edge of `rise_rel_req`. Rising edges that arrive while `evt_valid` is 1 change neither word.
- R7: After validation the width counter stays stopped until a rising edge of `cnt_rel_req`. A pulse accepted before that updates the rise word but never sets `evt_valid`.
- R8: The serial stream is the 22-bit value {rise coarse MSB..LSB, fine MSB..LSB, fall coarse MSB..LSB}, followed by zeros. `ser_out` shows the current bit, starting with the first one, and each rising edge of `shift_req` advances the stream by one bit. A level of `shift_req` held high counts as a single edge.
- R9: `phase_err` is 1 in the cycle after a `phase_smp` that has more than one change between adjacent bits, and 0 after any thermometer code.
- R10: A shift edge is ignored unless `evt_valid` is 1 and the fall word has already been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_smp | input | PHASES | Fine phase samples of the pulse, latest phase in the MSB |
| coarse_cnt | input | COARSE_W | Shared coarse count |
| min_width | input | WIDTH_W | Minimum pulse width in cycles for a valid event |
| shift_req | input | 1 | Readout shift command (edge detected) |
| rise_rel_req | input | 1 | Releases the frozen rise register (edge detected) |
| cnt_rel_req | input | 1 | Re-enables the width counter (edge detected) |
| evt_valid | output | 1 | A validated event is held |
| phase_err | output | 1 | The previous phase sample was not a thermometer code |
| ser_out | output | 1 | Current bit of the serial readout stream |

## Verification
The bench sweeps small thresholds, including 0, against pulse widths on both sides of each threshold. A counter that is off by one would validate pulses one cycle too short, or reject pulses of exactly the threshold width. The bench also checks that a noise pulse is overwritten and that a pulse arriving during the frozen state leaves the held words intact. A design that failed to freeze the rise register would read out the newest pulse instead of the held one. The bench further covers a rise release without a counter release, which must never validate; a shift issued before the fall capture, which would drop the first stream bit; a shift held high, which must advance only once; and non-thermometer phase samples.

// File: rtl/pstc_pkg.sv
package pstc_pkg;
  // Readout control lines, in the order of the edge-detector vector
  typedef enum int {
    CTL_SHIFT    = 0,
    CTL_RISE_REL = 1,
    CTL_CNT_REL  = 2
  } ctl_idx_e;
  localparam int NUM_CTL = 3;
endpackage

// File: rtl/pstc_edge_det.sv
module pstc_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~prev_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
  end
endmodule

// File: rtl/pstc_phase_enc.sv
module pstc_phase_enc #(
  parameter int PHASES = 4,
  localparam int FINE_W = $clog2(PHASES),
  localparam int CNT_W  = $clog2(PHASES + 1)
) (
  input  logic [PHASES-1:0] phase,
  output logic              level,
  output logic [FINE_W-1:0] fine,
  output logic              bad
);
  logic [PHASES-2:0] diff;
  logic [CNT_W-1:0]  ones;
  logic [CNT_W-1:0]  trans;

  for (genvar i = 0; i < PHASES - 1; i++) begin : g_diff
    assign diff[i] = phase[i] ^ phase[i+1];
  end

  always_comb begin
    ones  = '0;
    trans = '0;
    for (int i = 0; i < PHASES; i++)     ones  = ones  + CNT_W'(phase[i]);
    for (int i = 0; i < PHASES - 1; i++) trans = trans + CNT_W'(diff[i]);
  end

  assign level = phase[PHASES-1];
  assign fine  = FINE_W'(ones - CNT_W'(1));
  assign bad   = (trans > CNT_W'(1));
endmodule

// File: rtl/pstc_width_ctr.sv
module pstc_width_ctr #(
  parameter int WIDTH_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               level,
  input  logic [WIDTH_W-1:0] thr,
  output logic               hit
);
  logic               running_q, running_d;
  logic [WIDTH_W-1:0] cnt_q, cnt_d;
  logic [WIDTH_W:0]   base, hits;
  logic               active;

  always_comb begin
    active    = start | (running_q & level);
    base      = start ? '0 : {1'b0, cnt_q};
    hits      = base + (WIDTH_W+1)'(1);
    hit       = active & (hits >= {1'b0, thr});
    running_d = 1'b0;
    cnt_d     = cnt_q;
    if (active && !hit) begin
      running_d = 1'b1;
      cnt_d     = hits[WIDTH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      running_q <= running_d;
      cnt_q     <= cnt_d;
    end
  end

  AST_STOP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !running_q); // R3
  AST_NOISE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !level && !start) |=> !running_q); // R4
endmodule

// File: rtl/pstc_hit_regs.sv
module pstc_hit_regs #(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 2,
  localparam int RISE_W  = COARSE_W + FINE_W,
  localparam int CHAIN_W = RISE_W + COARSE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_load,
  input  logic [RISE_W-1:0]   rise_word,
  input  logic                fall_load,
  input  logic [COARSE_W-1:0] fall_word,
  input  logic                shift_en,
  output logic                ser_out
);
  logic [CHAIN_W-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) begin
      chain_d = {chain_q[CHAIN_W-2:0], 1'b0};
    end else begin
      if (rise_load) chain_d[CHAIN_W-1:COARSE_W] = rise_word;
      if (fall_load) chain_d[COARSE_W-1:0]       = fall_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign ser_out = chain_q[CHAIN_W-1];

  AST_RISE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_load && !shift_en) |=> $stable(chain_q[CHAIN_W-1:COARSE_W])); // R6
  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && (rise_load || fall_load))); // R10
endmodule

// File: rtl/pulse_stamp_channel.sv
module pulse_stamp_channel #(
  parameter int COARSE_W = 10,
  parameter int PHASES   = 4,
  parameter int WIDTH_W  = 7,
  localparam int FINE_W  = $clog2(PHASES),
  localparam int RISE_W  = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PHASES-1:0]   phase_smp,
  input  logic [COARSE_W-1:0] coarse_cnt,
  input  logic [WIDTH_W-1:0]  min_width,
  input  logic                shift_req,
  input  logic                rise_rel_req,
  input  logic                cnt_rel_req,
  output logic                evt_valid,
  output logic                phase_err,
  output logic                ser_out
);
  import pstc_pkg::*;

  logic [NUM_CTL-1:0] ctl_lvl, ctl_rise;
  logic               level, bad;
  logic [FINE_W-1:0]  fine;
  logic               lvl_q, valid_q, hold_q, armed_q, err_q;
  logic               valid_d, hold_d, armed_d;
  logic               rise_trig, fall_trig, accept, start, hit, fall_cap, shift_en;

  always_comb begin
    ctl_lvl               = '0;
    ctl_lvl[CTL_SHIFT]    = shift_req;
    ctl_lvl[CTL_RISE_REL] = rise_rel_req;
    ctl_lvl[CTL_CNT_REL]  = cnt_rel_req;
  end

  pstc_edge_det #(.N(NUM_CTL)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_lvl), .rise(ctl_rise)
  );

  pstc_phase_enc #(.PHASES(PHASES)) u_enc (
    .phase(phase_smp), .level(level), .fine(fine), .bad(bad)
  );

  pstc_width_ctr #(.WIDTH_W(WIDTH_W)) u_width (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level),
    .thr(min_width), .hit(hit)
  );

  pstc_hit_regs #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_hits (
    .clk(clk), .rst_n(rst_n),
    .rise_load(accept), .rise_word({coarse_cnt, fine}),
    .fall_load(fall_cap), .fall_word(coarse_cnt),
    .shift_en(shift_en), .ser_out(ser_out)
  );

  // Next-state logic
  always_comb begin
    rise_trig = level & ~lvl_q;
    fall_trig = ~level & lvl_q;
    accept    = rise_trig & ~valid_q;
    start     = accept & ~hold_q;
    fall_cap  = fall_trig & armed_q;
    shift_en  = ctl_rise[CTL_SHIFT] & valid_q & ~armed_q;

    valid_d = valid_q;
    if (hit)                        valid_d = 1'b1;
    else if (ctl_rise[CTL_RISE_REL]) valid_d = 1'b0;

    hold_d = hold_q;
    if (hit)                       hold_d = 1'b1;
    else if (ctl_rise[CTL_CNT_REL]) hold_d = 1'b0;

    armed_d = armed_q;
    if (hit)                    armed_d = 1'b1;
    else if (accept || fall_cap) armed_d = 1'b0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      valid_q <= 1'b0;
      hold_q  <= 1'b0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      lvl_q   <= level;
      valid_q <= valid_d;
      hold_q  <= hold_d;
      armed_q <= armed_d;
      err_q   <= bad;
    end
  end

  assign evt_valid = valid_q;
  assign phase_err = err_q;

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ctl_rise[CTL_RISE_REL]) |=> valid_q); // R6
  AST_FALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cap |-> valid_q); // R5
  AST_NO_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !hit); // R7
  AST_FROZEN_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !start); // R6
endmodule

// File: tb/pulse_stamp_channel_test.sv
module pulse_stamp_channel_test;
  localparam int CW  = 10;
  localparam int PH  = 4;
  localparam int WW  = 7;
  localparam int FW  = 2;
  localparam int TOT = CW + FW + CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PH-1:0] phase_smp;
  logic [CW-1:0] coarse_cnt;
  logic [WW-1:0] min_width;
  logic          shift_req, rise_rel_req, cnt_rel_req;
  logic          evt_valid, phase_err, ser_out;

  always #5 clk = ~clk;

  pulse_stamp_channel #(.COARSE_W(CW), .PHASES(PH), .WIDTH_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .phase_smp(phase_smp), .coarse_cnt(coarse_cnt),
    .min_width(min_width), .shift_req(shift_req), .rise_rel_req(rise_rel_req),
    .cnt_rel_req(cnt_rel_req), .evt_valid(evt_valid), .phase_err(phase_err),
    .ser_out(ser_out)
  );

  int            checks = 0;
  int            errors = 0;
  logic [CW-1:0] cyc = '0;
  logic [CW-1:0] last_c, rise_c, fall_c;
  logic [FW-1:0] rise_f;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic [PH-1:0] ph, input logic sh, input logic rr, input logic cr);
    @(negedge clk);
    phase_smp    = ph;
    shift_req    = sh;
    rise_rel_req = rr;
    cnt_rel_req  = cr;
    coarse_cnt   = cyc;
    last_c       = cyc;
    cyc          = cyc + 1'b1;
    @(posedge clk);
    #1;
  endtask

  // width high cycles; f = rise fine code; ff = ones in falling sample
  task automatic pulse(input int width, input int f, input int ff, input bit shift_last);
    step(PH'(4'hF << (PH - 1 - f)), 1'b0, 1'b0, 1'b0);
    rise_c = last_c;
    rise_f = FW'(f);
    for (int k = 1; k < width; k++)
      step('1, shift_last && (k == width - 1), 1'b0, 1'b0);
    step(PH'(4'hF >> (PH - ff)), 1'b0, 1'b0, 1'b0);
    fall_c = last_c;
    step('0, 1'b0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic readout(input string req, input logic [TOT-1:0] exp);
    logic [TOT-1:0] got;
    got = '0;
    for (int i = 0; i < TOT; i++) begin
      got[TOT-1-i] = ser_out;
      step('0, 1'b1, 1'b0, 1'b0);
      step('0, 1'b0, 1'b0, 1'b0);
    end
    check(req, 32'(got), 32'(exp));
  endtask

  task automatic release_all();
    step('0, 1'b0, 1'b1, 1'b0);
    step('0, 1'b0, 1'b0, 1'b1);
    step('0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [TOT-1:0] held;
    rst_n = 1'b0; phase_smp = '0; coarse_cnt = '0; min_width = '0;
    shift_req = 1'b0; rise_rel_req = 1'b0; cnt_rel_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", 32'(evt_valid), 0);
    check("R1 err in reset", 32'(phase_err), 0);
    check("R1 ser in reset", 32'(ser_out), 0);
    @(negedge clk) rst_n = 1'b1;
    step('0, 1'b0, 1'b0, 1'b0);
    check("R1 valid after reset", 32'(evt_valid), 0);

    // R3 / R2 / R5 / R8 sweep of thresholds against widths
    for (int thr = 0; thr <= 4; thr++) begin
      min_width = WW'(thr);
      for (int w = 1; w <= 5; w++) begin
        bit ev;
        ev = (w >= ((thr == 0) ? 1 : thr));
        pulse(w, w % 4, (w + 1) % 4, 1'b0);
        check($sformatf("R3 thr=%0d w=%0d", thr, w), 32'(evt_valid), 32'(ev));
        if (ev) begin
          readout("R2 R5 R8 word", {rise_c, rise_f, fall_c});
          release_all();
          check("R6 valid after release", 32'(evt_valid), 0);
        end
      end
    end

    // R4: noise pulse overwritten by the next event
    min_width = 3;
    pulse(2, 1, 0, 1'b0);
    check("R4 noise not valid", 32'(evt_valid), 0);
    pulse(3, 2, 1, 1'b0);
    check("R4 long valid", 32'(evt_valid), 1);
    readout("R4 later word", {rise_c, rise_f, fall_c});
    release_all();

    // R6: pulse during frozen state is ignored
    pulse(4, 3, 2, 1'b0);
    held = {rise_c, rise_f, fall_c};
    pulse(5, 0, 1, 1'b0);
    check("R6 still valid", 32'(evt_valid), 1);
    readout("R6 held word", held);
    release_all();

    // R7: rise release alone does not re-enable validation
    min_width = 2;
    pulse(3, 1, 1, 1'b0);
    readout("R7 first word", {rise_c, rise_f, fall_c});
    step('0, 1'b0, 1'b1, 1'b0);
    step('0, 1'b0, 1'b0, 1'b0);
    pulse(4, 2, 2, 1'b0);
    check("R7 held counter no valid", 32'(evt_valid), 0);
    step('0, 1'b0, 1'b0, 1'b1);
    step('0, 1'b0, 1'b0, 1'b0);
    pulse(2, 2, 3, 1'b0);
    check("R7 valid after counter release", 32'(evt_valid), 1);
    readout("R7 second word", {rise_c, rise_f, fall_c});
    release_all();

    // R10: shift while the fall is still pending is ignored
    pulse(4, 1, 2, 1'b1);
    readout("R10 word intact", {rise_c, rise_f, fall_c});
    release_all();

    // R8: held shift level advances once
    pulse(3, 3, 1, 1'b0);
    held = {rise_c, rise_f, fall_c};
    check("R8 first bit", 32'(ser_out), 32'(held[TOT-1]));
    step('0, 1'b1, 1'b0, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0, 1'b0);
    check("R8 single advance", 32'(ser_out), 32'(held[TOT-2]));
    release_all();

    // R9: thermometer code check
    step(4'b0101, 1'b0, 1'b0, 1'b0);
    check("R9 err 0101", 32'(phase_err), 1);
    step(4'b0010, 1'b0, 1'b0, 1'b0);
    check("R9 err 0010", 32'(phase_err), 1);
    step(4'b0011, 1'b0, 1'b0, 1'b0);
    check("R9 ok 0011", 32'(phase_err), 0);
    step(4'b0000, 1'b0, 1'b0, 1'b0);
    check("R9 ok 0000", 32'(phase_err), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule